// File: doc/BRIEF.md
# Interrupt Pin Routing and Servicing Engine

This block turns a bank of interrupt input pins into memory-write style messages. Each pin owns a 64-bit routing entry, held inside the block. The entry selects edge or level behaviour, a mask, an 8-bit vector, a 3-bit delivery mode, a destination mode bit and a 16-bit destination. A pending bit per pin records requests. Pins that are pending, unmasked and not waiting for completion are granted one at a time, lowest index first. Each grant produces an address/data pair on a valid/ready output channel.

Level pins keep a completion flag that is set when their message is issued. The flag holds further messages back until an end-of-interrupt strobe arrives with the entry's vector. Input 0 has no entry of its own and is folded onto pin 2. An update port writes whole entries and a separate read port returns them. The completion flag shows up in the read data but cannot be written.

Entry layout, bit positions:

| Bits | Field |
|------|-------|
| 7:0 | vector |
| 10:8 | delivery mode |
| 11 | destination mode |
| 14 | completion flag (read-only) |
| 15 | trigger (1 = level, 0 = edge) |
| 16 | mask (1 = masked) |
| 63:48 | destination |

Message formats:
- Address: `MSG_BASE` (default 0xFEE00000) OR destination<<4 OR destination-mode<<2.
- Data: vector OR delivery-mode<<8 OR trigger<<15.

Top module: `intr_route_engine`

## Requirements
- R1: After reset no message is valid, every entry reads back as only the mask bit set (0x10000), and reads of an index at or above the pin count return 0.
- R2: A request on input 0 acts on pin 2: it is serviced with entry 2 and reported with source pin 2; pin 0 never issues a message.
- R3: A rising input on an unmasked edge pin produces exactly one message, even if the input stays high, with address and data built from the entry as described above.
- R4: A rising input on a masked edge pin is discarded; unmasking the pin later produces no message.
- R5: A high unmasked level pin issues one message and sets its completion flag (read bit 14); while the flag is set, no further message is issued for that pin.
- R6: An end-of-interrupt strobe clears the completion flag of every entry whose flag is set and whose vector equals the strobe's vector; if the pin is still high a new message follows. A non-matching vector changes nothing.
- R7: A level pin that goes low before being serviced loses its request; unmasking afterwards issues nothing.
- R8: When several pins are eligible together, messages leave in ascending pin order, one per cycle when the channel is ready.
- R9: While msg_valid is high and msg_ready low, the address, data and pin outputs hold steady, and no eligible request is lost.
- R10: An entry write keeps the completion flag of a level entry, clears it when the new entry is edge-triggered, and ignores bit 14 of the write data.
- R11: A masked level pin that is held high stays pending and is serviced as soon as it is unmasked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_raw | input | NPINS | Raw interrupt input levels |
| tbl_we | input | 1 | Entry write strobe |
| tbl_widx | input | IDX_W | Entry index to write |
| tbl_wdata | input | 64 | New entry value |
| tbl_ridx | input | IDX_W | Entry index to read |
| tbl_rdata | output | 64 | Entry value including completion flag |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vec | input | 8 | Vector carried by the strobe |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_addr | output | 32 | Message address word |
| msg_data | output | 32 | Message data word |
| msg_pin | output | IDX_W | Pin that produced the message |

## Verification
The assertions take for granted that the consumer does not retract msg_ready in ways that matter to the hold check. They also assume that entry writes do not target the pin being granted in the same cycle, and the checks that involve writes exclude those cycles. The stimulus changes pins, strobes and writes only one cycle after a clock edge. It writes entries only while their pins are idle or in a known state, and each scenario begins from a fresh reset, so no pending state carries over between scenarios.

// File: rtl/intr_route_pkg.sv
package intr_route_pkg;

    localparam int ENT_W     = 64;
    localparam int VEC_W     = 8;
    localparam int DM_W      = 3;
    localparam int DEST_W    = 16;

    localparam int DM_LSB    = 8;
    localparam int DMODE_BIT = 11;
    localparam int BUSY_BIT  = 12;
    localparam int RIRR_BIT  = 14;
    localparam int TRIG_BIT  = 15;
    localparam int MASK_BIT  = 16;
    localparam int DEST_LSB  = 48;

    localparam int A_DEST_SH  = 4;
    localparam int A_DMODE_SH = 2;
    localparam int D_DM_SH    = 8;
    localparam int D_TRIG_SH  = 15;

    localparam logic [ENT_W-1:0] RO_BITS   = (64'd1 << RIRR_BIT) | (64'd1 << BUSY_BIT);
    localparam logic [ENT_W-1:0] RESET_ENT = 64'd1 << MASK_BIT;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              mask;
        logic              level;
        logic              dmode;
        logic [DM_W-1:0]   dm;
        logic [VEC_W-1:0]  vec;
    } rte_t;

    function automatic rte_t rte_decode(input logic [ENT_W-1:0] e);
        rte_t f;
        f.dest  = e[DEST_LSB +: DEST_W];
        f.mask  = e[MASK_BIT];
        f.level = e[TRIG_BIT];
        f.dmode = e[DMODE_BIT];
        f.dm    = e[DM_LSB +: DM_W];
        f.vec   = e[VEC_W-1:0];
        return f;
    endfunction

    function automatic logic [31:0] rte_addr(input rte_t f, input logic [31:0] base);
        return base | (32'(f.dest) << A_DEST_SH) | (32'(f.dmode) << A_DMODE_SH);
    endfunction

    function automatic logic [31:0] rte_data(input rte_t f);
        return 32'(f.vec) | (32'(f.dm) << D_DM_SH) | (32'(f.level) << D_TRIG_SH);
    endfunction

endpackage

// File: rtl/irq_pin_front.sv
module irq_pin_front #(
    parameter int NPINS     = 24,
    parameter int REMAP_SRC = 0,
    parameter int REMAP_DST = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_raw,
    output logic [NPINS-1:0] pin_lvl,
    output logic [NPINS-1:0] pin_rise
);

    typedef struct packed {
        logic [NPINS-1:0] prev;
    } front_t;

    front_t front_q, front_d;
    logic [NPINS-1:0] eff;

    for (genvar i = 0; i < NPINS; i++) begin : g_map
        if (i == REMAP_SRC) begin : g_src
            assign eff[i] = 1'b0;
        end else if (i == REMAP_DST) begin : g_dst
            assign eff[i] = pin_raw[i] | pin_raw[REMAP_SRC];
        end else begin : g_thru
            assign eff[i] = pin_raw[i];
        end
    end

    always_comb begin
        front_d      = front_q;
        front_d.prev = eff;
        pin_lvl      = eff;
        pin_rise     = eff & ~front_q.prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) front_q <= '0;
        else        front_q <= front_d;
    end

endmodule

// File: rtl/irq_redir_table.sv
module irq_redir_table
    import intr_route_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ENT_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [ENT_W-1:0] rd_data,
    input  logic             eoi_valid,
    input  logic [VEC_W-1:0] eoi_vec,
    input  logic [NPINS-1:0] svc_set,
    input  logic [IDX_W-1:0] sel_idx,
    output logic [ENT_W-1:0] sel_ent,
    output logic [NPINS-1:0] mask_o,
    output logic [NPINS-1:0] level_o,
    output logic [NPINS-1:0] rirr_o
);

    localparam logic [IDX_W:0] NP_LIM = (IDX_W+1)'(NPINS);

    typedef struct packed {
        logic [NPINS-1:0][ENT_W-1:0] ent;
        logic [NPINS-1:0]            rirr;
    } tbl_t;

    tbl_t tbl_q, tbl_d;

    always_comb begin
        tbl_d = tbl_q;
        for (int i = 0; i < NPINS; i++) begin
            if (wr_en && wr_idx == IDX_W'(i)) begin
                tbl_d.ent[i]  = wr_data & ~RO_BITS;
                tbl_d.rirr[i] = tbl_q.rirr[i] & wr_data[TRIG_BIT];
            end
            if (eoi_valid && tbl_d.rirr[i] && tbl_d.ent[i][VEC_W-1:0] == eoi_vec) begin
                tbl_d.rirr[i] = 1'b0;
            end
            if (svc_set[i]) begin
                tbl_d.rirr[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPINS; i++) tbl_q.ent[i] <= RESET_ENT;
            tbl_q.rirr <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_flags
        assign mask_o[i]  = tbl_q.ent[i][MASK_BIT];
        assign level_o[i] = tbl_q.ent[i][TRIG_BIT];
        assign rirr_o[i]  = tbl_q.rirr[i];
    end

    always_comb begin
        rd_data = '0;
        if ({1'b0, rd_idx} < NP_LIM) begin
            rd_data = tbl_q.ent[rd_idx];
            rd_data[RIRR_BIT] = tbl_q.rirr[rd_idx];
        end
        sel_ent = '0;
        if ({1'b0, sel_idx} < NP_LIM) begin
            sel_ent = tbl_q.ent[sel_idx];
            sel_ent[RIRR_BIT] = tbl_q.rirr[sel_idx];
        end
    end

endmodule

// File: rtl/irq_svc_pick.sv
module irq_svc_pick #(
    parameter int NPINS = 24,
    parameter int IDX_W = 5
) (
    input  logic [NPINS-1:0] elig,
    output logic             found,
    output logic [IDX_W-1:0] idx,
    output logic [NPINS-1:0] grant
);

    logic [NPINS:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < NPINS; i++) begin : g_chain
        assign grant[i]    = elig[i] & ~seen[i];
        assign seen[i + 1] = seen[i] | elig[i];
    end

    assign found = seen[NPINS];

    always_comb begin
        idx = '0;
        for (int i = 0; i < NPINS; i++) begin
            if (grant[i]) idx = idx | IDX_W'(i);
        end
    end

endmodule

// File: rtl/intr_route_engine.sv
module intr_route_engine
    import intr_route_pkg::*;
#(
    parameter int          NPINS     = 24,
    parameter logic [31:0] MSG_BASE  = 32'hFEE0_0000,
    parameter int          REMAP_SRC = 0,
    parameter int          REMAP_DST = 2,
    localparam int         IDX_W     = $clog2(NPINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_raw,
    input  logic             tbl_we,
    input  logic [IDX_W-1:0] tbl_widx,
    input  logic [63:0]      tbl_wdata,
    input  logic [IDX_W-1:0] tbl_ridx,
    output logic [63:0]      tbl_rdata,
    input  logic             eoi_valid,
    input  logic [7:0]       eoi_vec,
    output logic             msg_valid,
    input  logic             msg_ready,
    output logic [31:0]      msg_addr,
    output logic [31:0]      msg_data,
    output logic [IDX_W-1:0] msg_pin
);

    typedef struct packed {
        logic [NPINS-1:0] pend;
        logic             vld;
        logic [IDX_W-1:0] pin;
        logic [31:0]      addr;
        logic [31:0]      data;
    } eng_t;

    eng_t eng_q, eng_d;

    logic [NPINS-1:0] lvl_v, rise_v, mask_v, level_v, rirr_v;
    logic [NPINS-1:0] elig, grant, svc_lvl, edge_clr;
    logic             found, load_w;
    logic [IDX_W-1:0] pick_idx;
    logic [63:0]      sel_ent;
    rte_t             sel_f;

    irq_pin_front #(
        .NPINS(NPINS), .REMAP_SRC(REMAP_SRC), .REMAP_DST(REMAP_DST)
    ) u_front (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw),
        .pin_lvl(lvl_v), .pin_rise(rise_v)
    );

    irq_redir_table #(.NPINS(NPINS), .IDX_W(IDX_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tbl_we), .wr_idx(tbl_widx), .wr_data(tbl_wdata),
        .rd_idx(tbl_ridx), .rd_data(tbl_rdata),
        .eoi_valid(eoi_valid), .eoi_vec(eoi_vec),
        .svc_set(svc_lvl), .sel_idx(pick_idx), .sel_ent(sel_ent),
        .mask_o(mask_v), .level_o(level_v), .rirr_o(rirr_v)
    );

    assign elig = eng_q.pend & ~mask_v & ~(level_v & rirr_v);

    irq_svc_pick #(.NPINS(NPINS), .IDX_W(IDX_W)) u_pick (
        .elig(elig), .found(found), .idx(pick_idx), .grant(grant)
    );

    always_comb begin
        eng_d    = eng_q;
        sel_f    = rte_decode(sel_ent);
        load_w   = found && (!eng_q.vld || msg_ready);
        svc_lvl  = '0;
        edge_clr = '0;
        if (load_w) begin
            if (sel_f.level) svc_lvl  = grant;
            else             edge_clr = grant;
        end
        for (int i = 0; i < NPINS; i++) begin
            if (level_v[i]) eng_d.pend[i] = lvl_v[i];
            else eng_d.pend[i] = (eng_q.pend[i] & ~edge_clr[i]) | (rise_v[i] & ~mask_v[i]);
        end
        if (load_w) begin
            eng_d.vld  = 1'b1;
            eng_d.pin  = pick_idx;
            eng_d.addr = rte_addr(sel_f, MSG_BASE);
            eng_d.data = rte_data(sel_f);
        end else if (eng_q.vld && msg_ready) begin
            eng_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign msg_valid = eng_q.vld;
    assign msg_addr  = eng_q.addr;
    assign msg_data  = eng_q.data;
    assign msg_pin   = eng_q.pin;

    // R9
    msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data) && $stable(msg_pin));

    // R2
    no_src_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> msg_pin != IDX_W'(REMAP_SRC));

    // R5
    rirr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_w && level_v[pick_idx] && !(tbl_we && tbl_widx == pick_idx) |=> rirr_v[$past(pick_idx)]);

    // R5
    no_coalesced_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_w |-> !(level_v[pick_idx] && rirr_v[pick_idx]));

    // R3
    edge_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_w && !level_v[pick_idx] && !tbl_we && !rise_v[pick_idx] |=> !eng_q.pend[$past(pick_idx)]);

    // R4
    masked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tbl_we |=> (eng_q.pend & $past(~level_v & mask_v & ~eng_q.pend)) == '0);

    // R8
    low_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_w |-> (elig & ((NPINS'(1) << pick_idx) - NPINS'(1))) == '0);

endmodule

// File: tb/intr_route_engine_tb.sv
module intr_route_engine_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 24;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [NP-1:0] pin_raw;
    logic        tbl_we;
    logic [4:0]  tbl_widx;
    logic [63:0] tbl_wdata;
    logic [4:0]  tbl_ridx;
    logic [63:0] tbl_rdata;
    logic        eoi_valid;
    logic [7:0]  eoi_vec;
    logic        msg_valid;
    logic        msg_ready;
    logic [31:0] msg_addr;
    logic [31:0] msg_data;
    logic [4:0]  msg_pin;

    int n_chk = 0;
    int n_err = 0;

    int          cap_n = 0;
    int          cap_pin  [64];
    logic [31:0] cap_addr [64];
    logic [31:0] cap_data [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_route_engine u_dut (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw),
        .tbl_we(tbl_we), .tbl_widx(tbl_widx), .tbl_wdata(tbl_wdata),
        .tbl_ridx(tbl_ridx), .tbl_rdata(tbl_rdata),
        .eoi_valid(eoi_valid), .eoi_vec(eoi_vec),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data), .msg_pin(msg_pin)
    );

    always @(negedge clk) begin
        if (rst_n && msg_valid && msg_ready && cap_n < 64) begin
            cap_pin[cap_n]  = int'(msg_pin);
            cap_addr[cap_n] = msg_addr;
            cap_data[cap_n] = msg_data;
            cap_n = cap_n + 1;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk = n_chk + 1;
        n_err = n_err + 1;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    function automatic logic [63:0] mk(input logic [7:0] vec, input logic [2:0] dm, input logic dmode,
                                       input logic lvl, input logic msk, input logic [15:0] dest);
        logic [63:0] e;
        e = '0;
        e[7:0]   = vec;
        e[10:8]  = dm;
        e[11]    = dmode;
        e[15]    = lvl;
        e[16]    = msk;
        e[63:48] = dest;
        return e;
    endfunction

    function automatic logic [31:0] exp_addr(input logic [15:0] dest, input logic dmode);
        return 32'hFEE0_0000 | ({16'h0, dest} << 4) | ({31'h0, dmode} << 2);
    endfunction

    function automatic logic [31:0] exp_data(input logic [7:0] vec, input logic [2:0] dm, input logic lvl);
        return {24'h0, vec} | ({29'h0, dm} << 8) | ({31'h0, lvl} << 15);
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_err = n_err + 1;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0; pin_raw = '0; tbl_we = 1'b0; tbl_widx = '0; tbl_wdata = '0;
        tbl_ridx = '0; eoi_valid = 1'b0; eoi_vec = '0; msg_ready = 1'b1;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic wr(input int idx, input logic [63:0] val);
        tbl_we = 1'b1; tbl_widx = 5'(idx); tbl_wdata = val;
        step(1);
        tbl_we = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [63:0] val);
        tbl_ridx = 5'(idx);
        #1;
        val = tbl_rdata;
    endtask

    task automatic eoi(input logic [7:0] v);
        eoi_valid = 1'b1; eoi_vec = v;
        step(1);
        eoi_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [63:0] v;
        do_reset();
        chk(msg_valid == 1'b0, "R1", "valid after reset", msg_valid, 0);
        rd(0, v);  chk(v == 64'h10000, "R1", "entry 0", v, 64'h10000);
        rd(23, v); chk(v == 64'h10000, "R1", "entry 23", v, 64'h10000);
        rd(30, v); chk(v == 64'h0, "R1", "entry out of range", v, 0);
    endtask

    task automatic t_edge();
        int b;
        do_reset();
        wr(5, mk(8'h41, 3'd1, 1'b1, 1'b0, 1'b0, 16'h0a00));
        b = cap_n;
        pin_raw[5] = 1'b1; step(4);
        pin_raw[5] = 1'b0; step(6);
        chk(cap_n - b == 1, "R3", "edge message count", cap_n - b, 1);
        chk(cap_pin[b] == 5, "R3", "edge pin", cap_pin[b], 5);
        chk(cap_addr[b] == exp_addr(16'h0a00, 1'b1), "R3", "edge addr", cap_addr[b], exp_addr(16'h0a00, 1'b1));
        chk(cap_data[b] == exp_data(8'h41, 3'd1, 1'b0), "R3", "edge data", cap_data[b], exp_data(8'h41, 3'd1, 1'b0));
    endtask

    task automatic t_remap();
        int b;
        do_reset();
        wr(0, mk(8'h10, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0100));
        wr(2, mk(8'h22, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0200));
        b = cap_n;
        pin_raw[0] = 1'b1; step(2);
        pin_raw[0] = 1'b0; step(6);
        chk(cap_n - b == 1, "R2", "remap count", cap_n - b, 1);
        chk(cap_pin[b] == 2, "R2", "remap pin", cap_pin[b], 2);
        chk(cap_data[b] == exp_data(8'h22, 3'd0, 1'b0), "R2", "remap data", cap_data[b], exp_data(8'h22, 3'd0, 1'b0));
    endtask

    task automatic t_mask_edge();
        int b;
        do_reset();
        wr(6, mk(8'h33, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0300));
        b = cap_n;
        pin_raw[6] = 1'b1; step(2);
        pin_raw[6] = 1'b0; step(3);
        wr(6, mk(8'h33, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0300));
        step(6);
        chk(cap_n - b == 0, "R4", "masked edge dropped", cap_n - b, 0);
        pin_raw[6] = 1'b1; step(2);
        pin_raw[6] = 1'b0; step(6);
        chk(cap_n - b == 1, "R4", "unmasked edge after drop", cap_n - b, 1);
    endtask

    task automatic t_level();
        int b;
        logic [63:0] v;
        do_reset();
        wr(8, mk(8'h50, 3'd0, 1'b0, 1'b1, 1'b0, 16'h0400));
        b = cap_n;
        pin_raw[8] = 1'b1; step(8);
        chk(cap_n - b == 1, "R5", "level message count", cap_n - b, 1);
        chk(cap_data[b] == exp_data(8'h50, 3'd0, 1'b1), "R5", "level data", cap_data[b], exp_data(8'h50, 3'd0, 1'b1));
        rd(8, v); chk(v[14] == 1'b1, "R5", "completion flag set", v[14], 1);
        step(10);
        chk(cap_n - b == 1, "R5", "coalesced while flag set", cap_n - b, 1);
    endtask

    task automatic t_eoi();
        int b;
        logic [63:0] v;
        do_reset();
        wr(8, mk(8'h50, 3'd0, 1'b0, 1'b1, 1'b0, 16'h0400));
        b = cap_n;
        pin_raw[8] = 1'b1; step(8);
        eoi(8'h51); step(6);
        chk(cap_n - b == 1, "R6", "mismatched vector no resend", cap_n - b, 1);
        rd(8, v); chk(v[14] == 1'b1, "R6", "flag kept on mismatch", v[14], 1);
        eoi(8'h50); step(6);
        chk(cap_n - b == 2, "R6", "resend after matching eoi", cap_n - b, 2);
        rd(8, v); chk(v[14] == 1'b1, "R6", "flag set again", v[14], 1);
        pin_raw[8] = 1'b0; step(2);
        eoi(8'h50); step(6);
        rd(8, v); chk(v[14] == 1'b0, "R6", "flag cleared by eoi", v[14], 0);
        chk(cap_n - b == 2, "R6", "no send with pin low", cap_n - b, 2);
    endtask

    task automatic t_level_drop();
        int b;
        do_reset();
        wr(9, mk(8'h60, 3'd0, 1'b0, 1'b1, 1'b1, 16'h0500));
        b = cap_n;
        pin_raw[9] = 1'b1; step(4);
        pin_raw[9] = 1'b0; step(2);
        wr(9, mk(8'h60, 3'd0, 1'b0, 1'b1, 1'b0, 16'h0500));
        step(6);
        chk(cap_n - b == 0, "R7", "dropped level not sent", cap_n - b, 0);
    endtask

    task automatic t_level_hold();
        int b;
        do_reset();
        wr(10, mk(8'h61, 3'd2, 1'b0, 1'b1, 1'b1, 16'h0600));
        b = cap_n;
        pin_raw[10] = 1'b1; step(6);
        chk(cap_n - b == 0, "R11", "masked level held back", cap_n - b, 0);
        wr(10, mk(8'h61, 3'd2, 1'b0, 1'b1, 1'b0, 16'h0600));
        step(6);
        chk(cap_n - b == 1, "R11", "served after unmask", cap_n - b, 1);
        chk(cap_pin[b] == 10, "R11", "served pin", cap_pin[b], 10);
    endtask

    task automatic t_order();
        int b;
        do_reset();
        wr(3, mk(8'h03, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0));
        wr(5, mk(8'h05, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0));
        wr(9, mk(8'h09, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0));
        b = cap_n;
        pin_raw[9] = 1'b1; pin_raw[5] = 1'b1; pin_raw[3] = 1'b1;
        step(2);
        pin_raw = '0; step(8);
        chk(cap_n - b == 3, "R8", "order count", cap_n - b, 3);
        chk(cap_pin[b] == 3, "R8", "first pin", cap_pin[b], 3);
        chk(cap_pin[b+1] == 5, "R8", "second pin", cap_pin[b+1], 5);
        chk(cap_pin[b+2] == 9, "R8", "third pin", cap_pin[b+2], 9);
    endtask

    task automatic t_backpressure();
        int b;
        logic [31:0] d0;
        do_reset();
        wr(4, mk(8'h44, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0700));
        wr(7, mk(8'h77, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0800));
        msg_ready = 1'b0;
        b = cap_n;
        pin_raw[4] = 1'b1; pin_raw[7] = 1'b1; step(2);
        pin_raw = '0; step(4);
        chk(msg_valid == 1'b1, "R9", "valid under stall", msg_valid, 1);
        chk(msg_pin == 5'd4, "R9", "pin under stall", msg_pin, 4);
        d0 = msg_data;
        step(3);
        chk(msg_pin == 5'd4 && msg_data == d0, "R9", "held data", msg_data, d0);
        msg_ready = 1'b1; step(6);
        chk(cap_n - b == 2, "R9", "no loss count", cap_n - b, 2);
        chk(cap_pin[b+1] == 7, "R9", "second after release", cap_pin[b+1], 7);
    endtask

    task automatic t_write_flag();
        int b;
        logic [63:0] v;
        do_reset();
        wr(11, mk(8'h70, 3'd0, 1'b0, 1'b1, 1'b0, 16'h0900));
        b = cap_n;
        pin_raw[11] = 1'b1; step(8);
        wr(11, mk(8'h70, 3'd4, 1'b0, 1'b1, 1'b0, 16'h0900));
        step(4);
        rd(11, v); chk(v[14] == 1'b1, "R10", "flag kept on level rewrite", v[14], 1);
        chk(cap_n - b == 1, "R10", "no resend after rewrite", cap_n - b, 1);
        wr(11, mk(8'h70, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0900));
        step(2);
        rd(11, v); chk(v[14] == 1'b0, "R10", "flag cleared by edge rewrite", v[14], 0);
        wr(12, mk(8'h71, 3'd0, 1'b0, 1'b1, 1'b1, 16'h0) | 64'h4000);
        step(1);
        rd(12, v); chk(v[14] == 1'b0, "R10", "written flag ignored", v[14], 0);
    endtask

    initial begin
        rst_n = 1'b0; pin_raw = '0; tbl_we = 1'b0; tbl_widx = '0; tbl_wdata = '0;
        tbl_ridx = '0; eoi_valid = 1'b0; eoi_vec = '0; msg_ready = 1'b1;
        t_reset();
        t_edge();
        t_remap();
        t_mask_edge();
        t_level();
        t_eoi();
        t_level_drop();
        t_level_hold();
        t_order();
        t_backpressure();
        t_write_flag();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule